// File: doc/BRIEF.md
# Sixteen-bit multi-cycle processor core with memory stack

This block is a small processor that runs fixed-width 16-bit instructions out of a byte-addressed 64 KB memory. It has eight 16-bit general registers, with register 0 held at zero. It also has a program counter, a stack pointer, and three condition flags: zero, carry and negative. Each instruction passes through a fetch step, then an execute step, and then an optional memory step. The only link to memory is a request/ready port that carries one 16-bit word per access, always at an even byte address. That port is also how the instruction stream reaches the core.

Once reset is released, the core starts fetching at address 0 and keeps running until it reaches the halt opcode. From then on it makes no more memory requests and holds `halted` high until the next reset. Every branch, jump and call is PC-relative and counted in words. The stack is kept in memory and grows toward lower addresses. Subroutine linkage uses that stack through a call opcode and a return opcode.

Top module: `cpu16_core`

## Requirements
- R1: While reset is asserted and just after it is released, `mem_valid` is 1, `mem_we` is 0, `mem_addr` is 0x0000, `halted` is 0 and `cond_flags` is 0. All registers R1..R7 start at zero and SP starts at 0xFFFE.
- R2: An instruction is the 16-bit word read from memory at the PC, after which the PC advances by 2. Every access has bit 0 of `mem_addr` clear. A request keeps its address and direction steady until `mem_ready` is seen. On a read, `mem_rdata` is taken in the cycle where `mem_ready` is high.
- R3: Opcode 0x0 (bits 15:12) is register arithmetic. The fields are rd in 11:9, rs1 in 8:6, rs2 in 5:3 and op in 2:0. The op codes are 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 move rs1, 6 shift left and 7 logical shift right, each shift by rs2[3:0]. `cond_flags` is {negative, carry, zero}: zero means the result is 0, and negative is result bit 15. Carry is the carry out for add, the borrow (rs1 < rs2) for subtract, and the last bit shifted out for shifts (0 when the amount is 0). Carry is 0 for the other ops.
- R4: Opcodes 0x1, 0x2 and 0x3 use imm6 in bits 5:0, sign-extended. 0x1 gives rd = rs1 + imm6, with flags as for an add of the 16-bit extended immediate. 0x2 gives rd = imm6. 0x3 gives rd = imm6 << 8.
- R5: Only opcodes 0x0 and 0x1 change `cond_flags`. All other instructions leave the flags as they were.
- R6: LOAD (0x4) sets rd = mem[(rs1 + imm6) with bit 0 cleared]. STORE (0x5) writes the register named in bits 11:9 to that address.
- R7: Register 0 always reads as zero, and any write to it is dropped.
- R8: BEQ (0x6) and BNE (0x7) compare the register in bits 11:9 with the register in bits 8:6. When the branch is taken, PC becomes the incremented PC plus imm6*2. The flags are not consulted.
- R9: JMP (0x8) sets PC to the incremented PC plus imm12*2, where imm12 is bits 11:0, sign-extended.
- R10: PUSH (0xC) first lowers SP by 2 and then stores the register in bits 11:9 at the new SP. POP (0xD) loads that register from SP and then raises SP by 2.
- R11: CALL (0xE) pushes the incremented PC and then jumps as JMP does. RET (0x9) pops the PC from the stack.
- R12: HALT (0xF) makes `halted` go high and stay high. From then on no memory request is made.
- R13: Opcodes 0xA and 0xB do nothing except advance the PC, whatever their low 12 bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_valid | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Byte address of the word, always even |
| mem_wdata | output | 16 | Word to write |
| mem_ready | input | 1 | Memory completes the pending request this cycle |
| mem_rdata | input | 16 | Read word, valid while mem_ready is high |
| halted | output | 1 | Core has executed HALT |
| cond_flags | output | 3 | {negative, carry, zero} |

## Verification
The arithmetic unit is swept over every op code and every pair taken from a set of eight operands. The operands are chosen to separate the cases that matter: zero versus nonzero, a set top bit, all ones, and shift amounts of 0, 1, 4 and 15, where carry must be the last bit shifted out. ADDI, LI and LUI are each swept over all 64 immediates. This checks that sign extension is right, and that LI and LUI leave a previously set zero flag untouched. Short programs then cover each remaining behaviour:
- taken and untaken equality tests;
- a counted backward loop;
- forward and backward jumps;
- an odd load/store base;
- nested calls, whose return addresses must appear at 0xFFFC and 0xFFFA;
- push/pop order;
- writes aimed at R0;
- the two spare opcodes with all-ones fields.

Memory latency cycles between 0, 1 and 2 wait cycles, so results must not depend on when ready arrives.

// File: rtl/cpu16_core.sv
module cpu16_core #(
  parameter logic [15:0] RESET_PC = 16'h0000,
  parameter logic [15:0] RESET_SP = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_valid,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [15:0] mem_rdata,
  output logic        halted,
  output logic [2:0]  cond_flags
);

  localparam logic [3:0] OP_ALU   = 4'h0;
  localparam logic [3:0] OP_ADDI  = 4'h1;
  localparam logic [3:0] OP_LI    = 4'h2;
  localparam logic [3:0] OP_LUI   = 4'h3;
  localparam logic [3:0] OP_LOAD  = 4'h4;
  localparam logic [3:0] OP_STORE = 4'h5;
  localparam logic [3:0] OP_BEQ   = 4'h6;
  localparam logic [3:0] OP_BNE   = 4'h7;
  localparam logic [3:0] OP_JMP   = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hC;
  localparam logic [3:0] OP_POP   = 4'hD;
  localparam logic [3:0] OP_CALL  = 4'hE;
  localparam logic [3:0] OP_HALT  = 4'hF;

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_MEM, S_STOP} state_t;

  state_t      state;
  logic [15:0] pc, sp, ir, maddr, mwdata;
  logic        mwe, zf, cf, nf;
  logic [15:0] rf [0:7];

  logic [3:0]  opc;
  logic [2:0]  f_rd, f_rs1, f_rs2, f_aop;
  logic [15:0] simm6, simm12, rv_d, rv_a, rv_b;
  logic [3:0]  shamt;
  logic [16:0] alu_full, addi_full, shl_full, shr_full;
  logic [15:0] ea, br_tgt, jmp_tgt;
  logic        wb_en;
  logic [15:0] wb_data;

  assign opc    = ir[15:12];
  assign f_rd   = ir[11:9];
  assign f_rs1  = ir[8:6];
  assign f_rs2  = ir[5:3];
  assign f_aop  = ir[2:0];
  assign simm6  = {{10{ir[5]}}, ir[5:0]};
  assign simm12 = {{4{ir[11]}}, ir[11:0]};

  assign rv_d = (f_rd  == 3'd0) ? 16'h0000 : rf[f_rd];
  assign rv_a = (f_rs1 == 3'd0) ? 16'h0000 : rf[f_rs1];
  assign rv_b = (f_rs2 == 3'd0) ? 16'h0000 : rf[f_rs2];

  assign shamt    = rv_b[3:0];
  assign shl_full = {1'b0, rv_a} << shamt;
  assign shr_full = {rv_a, 1'b0} >> shamt;

  always_comb begin
    case (f_aop)
      3'd0:    alu_full = {1'b0, rv_a} + {1'b0, rv_b};
      3'd1:    alu_full = {1'b0, rv_a} - {1'b0, rv_b};
      3'd2:    alu_full = {1'b0, rv_a & rv_b};
      3'd3:    alu_full = {1'b0, rv_a | rv_b};
      3'd4:    alu_full = {1'b0, rv_a ^ rv_b};
      3'd5:    alu_full = {1'b0, rv_a};
      3'd6:    alu_full = shl_full;
      default: alu_full = {shr_full[0], shr_full[16:1]};
    endcase
  end

  assign addi_full = {1'b0, rv_a} + {1'b0, simm6};
  assign ea        = (rv_a + simm6) & 16'hFFFE;
  assign br_tgt    = pc + {simm6[14:0], 1'b0};
  assign jmp_tgt   = pc + {simm12[14:0], 1'b0};

  always_comb begin
    wb_en   = 1'b0;
    wb_data = alu_full[15:0];
    if (state == S_EXEC) begin
      case (opc)
        OP_ALU:  wb_en = 1'b1;
        OP_ADDI: begin wb_en = 1'b1; wb_data = addi_full[15:0]; end
        OP_LI:   begin wb_en = 1'b1; wb_data = simm6; end
        OP_LUI:  begin wb_en = 1'b1; wb_data = {simm6[7:0], 8'h00}; end
        default: wb_en = 1'b0;
      endcase
    end else if (state == S_MEM && mem_ready && (opc == OP_LOAD || opc == OP_POP)) begin
      wb_en   = 1'b1;
      wb_data = mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) rf[i] <= 16'h0000;
    end else if (wb_en && f_rd != 3'd0) begin
      rf[f_rd] <= wb_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_FETCH;
      pc     <= RESET_PC;
      sp     <= RESET_SP;
      ir     <= 16'h0000;
      maddr  <= 16'h0000;
      mwdata <= 16'h0000;
      mwe    <= 1'b0;
      zf     <= 1'b0;
      cf     <= 1'b0;
      nf     <= 1'b0;
    end else begin
      case (state)
        S_FETCH: if (mem_ready) begin
          ir    <= mem_rdata;
          pc    <= pc + 16'd2;
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          case (opc)
            OP_ALU: begin
              zf <= (alu_full[15:0] == 16'h0000);
              nf <= alu_full[15];
              cf <= alu_full[16];
            end
            OP_ADDI: begin
              zf <= (addi_full[15:0] == 16'h0000);
              nf <= addi_full[15];
              cf <= addi_full[16];
            end
            OP_LOAD: begin
              maddr <= ea;
              mwe   <= 1'b0;
              state <= S_MEM;
            end
            OP_STORE: begin
              maddr  <= ea;
              mwe    <= 1'b1;
              mwdata <= rv_d;
              state  <= S_MEM;
            end
            OP_BEQ: if (rv_d == rv_a) pc <= br_tgt;
            OP_BNE: if (rv_d != rv_a) pc <= br_tgt;
            OP_JMP: pc <= jmp_tgt;
            OP_RET, OP_POP: begin
              maddr <= sp;
              sp    <= sp + 16'd2;
              mwe   <= 1'b0;
              state <= S_MEM;
            end
            OP_PUSH: begin
              maddr  <= sp - 16'd2;
              sp     <= sp - 16'd2;
              mwe    <= 1'b1;
              mwdata <= rv_d;
              state  <= S_MEM;
            end
            OP_CALL: begin
              maddr  <= sp - 16'd2;
              sp     <= sp - 16'd2;
              mwe    <= 1'b1;
              mwdata <= pc;
              state  <= S_MEM;
            end
            OP_HALT: state <= S_STOP;
            default: ;
          endcase
        end
        S_MEM: if (mem_ready) begin
          state <= S_FETCH;
          if (opc == OP_RET)  pc <= mem_rdata;
          if (opc == OP_CALL) pc <= jmp_tgt;
        end
        default: ;
      endcase
    end
  end

  assign mem_valid  = (state == S_FETCH) || (state == S_MEM);
  assign mem_we     = (state == S_MEM) && mwe;
  assign mem_addr   = (state == S_FETCH) ? pc : maddr;
  assign mem_wdata  = mwdata;
  assign halted     = (state == S_STOP);
  assign cond_flags = {nf, cf, zf};

endmodule

// File: rtl/cpu16_core_checks.sv
module cpu16_core_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_we,
  input logic        halted,
  input logic [15:0] mem_addr,
  input logic [15:0] sp
);

  assert_even_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !mem_addr[0]);

  assert_hold_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_valid);

  assert_sp_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> (sp == $past(sp) + 16'd2 || sp == $past(sp) - 16'd2));

endmodule

bind cpu16_core cpu16_core_checks u_checks (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .halted(halted), .mem_addr(mem_addr), .sp(sp)
);

// File: tb/cpu16_core_test.sv
module cpu16_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = 16'h0000;
  logic        mem_valid, mem_we, halted;
  logic [15:0] mem_addr, mem_wdata;
  logic [2:0]  cond_flags;

  logic [15:0] mem [0:511];
  int checks = 0, errors = 0, lat = 0, runs = 0, pw = 0, wait_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cpu16_core uut (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .halted(halted), .cond_flags(cond_flags)
  );

  initial begin : mem_model
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ready = 1'b0; wait_cnt = 0;
      end else if (mem_ready) begin
        mem_ready = 1'b0; wait_cnt = 0;
      end else if (mem_valid) begin
        if (wait_cnt >= lat) begin
          mem_ready = 1'b1;
          if (mem_we) mem[mem_addr[9:1]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[9:1]];
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  function automatic logic [15:0] rr(int rd, int rs1, int rs2, int op);
    return {4'h0, 3'(rd), 3'(rs1), 3'(rs2), 3'(op)};
  endfunction
  function automatic logic [15:0] ii(int opc, int rd, int rs1, int imm);
    return {4'(opc), 3'(rd), 3'(rs1), 6'(imm)};
  endfunction
  function automatic logic [15:0] jj(int opc, int imm);
    return {4'(opc), 12'(imm)};
  endfunction
  function automatic int ix(int a);
    return (a >> 1) & 511;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fresh();
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
    pw = 0;
  endtask

  task automatic put(input logic [15:0] w);
    mem[pw] = w;
    pw++;
  endtask

  task automatic run_prog();
    rst_n = 1'b0;
    lat = runs % 3;
    runs++;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4000 && !halted; k++) @(negedge clk);
    chk("R12 program reaches HALT", 32'(halted), 32'd1);
  endtask

  logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h0004, 16'h000F,
                            16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5C3};

  initial begin : main
    int ua, ub, sh, r, res, c, ex;
    bit quiet;

    // R1 reset state at the ports
    fresh();
    repeat (3) @(negedge clk);
    chk("R1 reset mem_valid", 32'(mem_valid), 32'd1);
    chk("R1 reset mem_we", 32'(mem_we), 32'd0);
    chk("R1 reset mem_addr", 32'(mem_addr), 32'h0);
    chk("R1 reset halted", 32'(halted), 32'd0);
    chk("R1 reset flags", 32'(cond_flags), 32'd0);

    // R1 registers cleared by reset
    fresh();
    put(ii(3, 7, 0, 1));
    for (int rg = 1; rg <= 6; rg++) put(ii(5, rg, 7, 2 * rg));
    put(jj(15, 0));
    for (int rg = 1; rg <= 6; rg++) mem[ix(16'h100 + 2 * rg)] = 16'hFFFF;
    run_prog();
    for (int rg = 1; rg <= 6; rg++)
      chk($sformatf("R1 register %0d after reset", rg), 32'(mem[ix(16'h100 + 2 * rg)]), 32'h0);

    // R3 arithmetic sweep
    for (int op = 0; op < 8; op++) begin
      for (int ai = 0; ai < 8; ai++) begin
        for (int bi = 0; bi < 8; bi++) begin
          fresh();
          put(ii(3, 7, 0, 1));
          put(ii(4, 1, 7, 0));
          put(ii(4, 2, 7, 2));
          put(rr(3, 1, 2, op));
          put(ii(5, 3, 7, 4));
          put(jj(15, 0));
          mem[ix(16'h100)] = vals[ai];
          mem[ix(16'h102)] = vals[bi];
          run_prog();
          ua = int'(vals[ai]); ub = int'(vals[bi]); sh = ub & 15; c = 0;
          case (op)
            0: begin r = ua + ub; res = r & 16'hFFFF; c = (r >> 16) & 1; end
            1: begin res = (ua - ub) & 16'hFFFF; c = (ua < ub) ? 1 : 0; end
            2: res = ua & ub;
            3: res = ua | ub;
            4: res = ua ^ ub;
            5: res = ua;
            6: begin res = (ua << sh) & 16'hFFFF; c = (sh == 0) ? 0 : ((ua >> (16 - sh)) & 1); end
            default: begin res = ua >> sh; c = (sh == 0) ? 0 : ((ua >> (sh - 1)) & 1); end
          endcase
          ex = ((res >> 15) << 2) | (c << 1) | ((res == 0) ? 1 : 0);
          chk($sformatf("R3 op %0d a=%h b=%h result", op, vals[ai], vals[bi]),
              32'(mem[ix(16'h104)]), 32'(res));
          chk($sformatf("R3 op %0d a=%h b=%h flags", op, vals[ai], vals[bi]),
              32'(cond_flags), 32'(ex));
        end
      end
    end

    // R4 ADDI sweep with flags
    for (int imm = -32; imm < 32; imm++) begin
      for (int ai = 0; ai < 4; ai++) begin
        fresh();
        put(ii(3, 7, 0, 1));
        put(ii(4, 1, 7, 0));
        put(ii(1, 3, 1, imm));
        put(ii(5, 3, 7, 4));
        put(jj(15, 0));
        mem[ix(16'h100)] = (ai == 0) ? 16'h0000 : (ai == 1) ? 16'h0020 : (ai == 2) ? 16'h7FFF : 16'hFFFF;
        ua = int'(mem[ix(16'h100)]);
        run_prog();
        r = ua + (imm & 16'hFFFF);
        res = r & 16'hFFFF;
        ex = ((res >> 15) << 2) | (((r >> 16) & 1) << 1) | ((res == 0) ? 1 : 0);
        chk($sformatf("R4 ADDI a=%h imm=%0d result", ua, imm), 32'(mem[ix(16'h104)]), 32'(res));
        chk($sformatf("R4 ADDI a=%h imm=%0d flags", ua, imm), 32'(cond_flags), 32'(ex));
      end
    end

    // R4 LI and LUI sweep, R5 flags untouched by them and by STORE
    for (int imm = -32; imm < 32; imm++) begin
      fresh();
      put(ii(3, 7, 0, 1));
      put(rr(2, 0, 0, 0));
      put(ii(2, 3, 0, imm));
      put(ii(3, 4, 0, imm));
      put(ii(5, 3, 7, 4));
      put(ii(5, 4, 7, 6));
      put(jj(15, 0));
      run_prog();
      chk($sformatf("R4 LI imm=%0d", imm), 32'(mem[ix(16'h104)]), 32'(imm & 16'hFFFF));
      chk($sformatf("R4 LUI imm=%0d", imm), 32'(mem[ix(16'h106)]), 32'((imm << 8) & 16'hFFFF));
      chk($sformatf("R5 flags kept over LI/LUI imm=%0d", imm), 32'(cond_flags), 32'd1);
    end

    // R7 writes to register 0 are dropped
    fresh();
    put(ii(3, 7, 0, 1));
    put(ii(2, 1, 0, 5));
    put(rr(0, 1, 1, 0));
    put(ii(1, 0, 1, 3));
    put(ii(4, 0, 7, 0));
    put(ii(5, 0, 7, 4));
    put(jj(15, 0));
    mem[ix(16'h100)] = 16'hBEEF;
    mem[ix(16'h104)] = 16'h5555;
    run_prog();
    chk("R7 register 0 reads zero", 32'(mem[ix(16'h104)]), 32'h0);
    chk("R5 flags from last ADDI (5+3)", 32'(cond_flags), 32'd0);

    // R6 effective address with bit 0 cleared, positive and negative offsets
    fresh();
    put(ii(3, 7, 0, 1));
    put(ii(1, 6, 7, 1));
    put(ii(4, 1, 6, 2));
    put(ii(5, 1, 6, 5));
    put(ii(5, 1, 6, -1));
    put(jj(15, 0));
    mem[ix(16'h102)] = 16'h3C5A;
    run_prog();
    chk("R6 store at odd base +5", 32'(mem[ix(16'h106)]), 32'h3C5A);
    chk("R6 store at odd base -1", 32'(mem[ix(16'h100)]), 32'h3C5A);

    // R8 BEQ/BNE taken and untaken
    for (int bt = 0; bt < 2; bt++) begin
      for (int pr = 0; pr < 4; pr++) begin
        int va, vb;
        va = (pr < 2) ? 3 : -1;
        vb = (pr == 0) ? 3 : (pr == 1) ? 4 : (pr == 2) ? -1 : 31;
        fresh();
        put(ii(3, 7, 0, 1));
        put(ii(2, 1, 0, va));
        put(ii(2, 2, 0, vb));
        put(ii(6 + bt, 1, 2, 1));
        put(ii(2, 3, 0, 1));
        put(ii(5, 3, 7, 4));
        put(jj(15, 0));
        run_prog();
        ex = (((va == vb) ? 1 : 0) ^ bt) != 0 ? 0 : 1;
        chk($sformatf("R8 %s %0d vs %0d", bt ? "BNE" : "BEQ", va, vb), 32'(mem[ix(16'h104)]), 32'(ex));
      end
    end

    // R8 backward BNE loop
    for (int n = 1; n <= 6; n++) begin
      fresh();
      put(ii(3, 7, 0, 1));
      put(ii(2, 1, 0, n));
      put(ii(2, 2, 0, 0));
      put(ii(1, 2, 2, 3));
      put(ii(1, 1, 1, -1));
      put(ii(7, 1, 0, -3));
      put(ii(5, 2, 7, 4));
      put(jj(15, 0));
      run_prog();
      chk($sformatf("R8 backward loop n=%0d", n), 32'(mem[ix(16'h104)]), 32'(3 * n));
    end

    // R9 forward and backward jumps
    fresh();
    put(ii(3, 7, 0, 1));
    put(jj(8, 3));
    put(ii(2, 3, 0, 9));
    put(ii(5, 3, 7, 4));
    put(jj(15, 0));
    put(ii(2, 3, 0, 6));
    put(jj(8, -4));
    run_prog();
    chk("R9 jump forward then back", 32'(mem[ix(16'h104)]), 32'h6);

    // R10 push/pop order and stack pointer
    fresh();
    put(ii(3, 7, 0, 1));
    put(ii(2, 1, 0, 11));
    put(ii(2, 2, 0, -3));
    put(ii(12, 1, 0, 0));
    put(ii(12, 2, 0, 0));
    put(ii(13, 3, 0, 0));
    put(ii(13, 4, 0, 0));
    put(ii(5, 3, 7, 4));
    put(ii(5, 4, 7, 6));
    put(ii(12, 3, 0, 0));
    put(jj(15, 0));
    run_prog();
    chk("R10 first pop gets last push", 32'(mem[ix(16'h104)]), 32'hFFFD);
    chk("R10 second pop gets first push", 32'(mem[ix(16'h106)]), 32'd11);
    chk("R10 push after pops lands at 0xFFFC", 32'(mem[ix(16'hFFFC)]), 32'hFFFD);
    chk("R10 second push at 0xFFFA", 32'(mem[ix(16'hFFFA)]), 32'hFFFD);
    chk("R10 nothing at 0xFFFE", 32'(mem[ix(16'hFFFE)]), 32'h0);

    // R11 single call and return
    fresh();
    put(ii(3, 7, 0, 1));
    put(jj(14, 3));
    put(ii(5, 3, 7, 4));
    put(jj(15, 0));
    put(ii(2, 3, 0, 1));
    put(ii(2, 3, 0, 21));
    put(jj(9, 0));
    run_prog();
    chk("R11 call/return result", 32'(mem[ix(16'h104)]), 32'd21);
    chk("R11 return address pushed", 32'(mem[ix(16'hFFFC)]), 32'h0004);

    // R11 nested calls
    fresh();
    put(ii(3, 7, 0, 1));
    put(jj(14, 4));
    put(ii(5, 3, 7, 4));
    put(jj(15, 0));
    put(ii(1, 3, 3, 4));
    put(jj(9, 0));
    put(ii(2, 3, 0, 1));
    put(jj(14, -4));
    put(ii(1, 3, 3, 2));
    put(jj(9, 0));
    run_prog();
    chk("R11 nested result", 32'(mem[ix(16'h104)]), 32'd7);
    chk("R11 outer return address", 32'(mem[ix(16'hFFFC)]), 32'h0004);
    chk("R11 inner return address", 32'(mem[ix(16'hFFFA)]), 32'h0010);

    // R13 spare opcodes do nothing
    fresh();
    put(ii(3, 7, 0, 1));
    put(ii(2, 3, 0, 5));
    put(rr(5, 0, 0, 0));
    put(16'hAFFF);
    put(16'hBFFF);
    put(ii(5, 3, 7, 4));
    put(jj(15, 0));
    run_prog();
    chk("R13 spare opcodes keep registers", 32'(mem[ix(16'h104)]), 32'd5);
    chk("R13 spare opcodes keep flags", 32'(cond_flags), 32'd1);

    // R12 quiet after halt
    quiet = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (mem_valid || !halted) quiet = 1'b0;
    end
    chk("R12 no requests after HALT", 32'(quiet), 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule